// File: doc/BRIEF.md
# Prescaled Interval Timer with External Gate and Trigger

This block counts time intervals with an 8-bit down-counter fed by a 6-bit prescaler. The prescaler counts ticks from one of two sources. The first is an internal clock running at one quarter of the system clock. The second is an external input, sampled through a two-flop synchroniser and counted on its rising edges. When the counter finishes an interval it raises a single-cycle interrupt pulse and toggles a timer output. In single-pass mode it then stops. In modulo-n mode it reloads its start value and keeps running.

When the internal source is selected, a 2-bit code decides what the external input does. It can be ignored, act as a gate for the internal ticks, or act as a trigger. A trigger is either non-retriggerable or retriggerable. Software writes a start value and a configuration byte. A load strobe restarts the interval, and an enable level stops and resumes counting. The live count can be read at any time. Another instance can be chained by driving its interrupt pulse into the external input of this one.

Top module: `ptmr_top`

## Requirements
- R1: The configuration byte holds the prescaler modulo in bits 7..2, the clock source in bit 1 (1 internal, 0 external) and the count mode in bit 0 (1 modulo-n, 0 single-pass). The prescaler divides its tick source by its modulo field, where 1..63 divide by that value and 0 divides by 64.
- R2: A start value of 1..255 gives that many prescaler outputs per interval, and 0 gives 256.
- R3: Each end of count produces an `irq` pulse exactly one clock wide.
- R4: In single-pass mode the counter stops after one end of count. `count_q` then reads 0 and no further pulse appears until the next load.
- R5: In modulo-n mode the counter reloads the start value at end of count, so consecutive pulses are evenly spaced at prescale × start-value source ticks.
- R6: A high `load` restarts the interval. On the following cycle `count_q` equals the start value, and the prescaler restarts too.
- R7: While `run_en` is low the count holds its value. Raising `run_en` again resumes counting from that value.
- R8: The internal source gives one tick every 4 system clocks.
- R9: With the external source selected, each synchronised rising edge of `ext_in` is one tick. With `ext_in` idle the count does not move.
- R10: With the internal source and mode code 01, internal ticks count only while `ext_in` is high.
- R11: With the internal source and mode code 10, a falling edge of `ext_in` loads and starts the counter. Further falling edges are ignored until end of count.
- R12: With the internal source and mode code 11, every falling edge of `ext_in` reloads the start value.
- R13: `tout` toggles at every end of count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_init | input | 1 | Write `wr_data` to the start-value register |
| wr_cfg | input | 1 | Write `wr_data` to the configuration byte |
| wr_data | input | 8 | Write data |
| load | input | 1 | Restart from the start value |
| run_en | input | 1 | Counting enable |
| ext_mode | input | 2 | External input role: 00 clock, 01 gate, 10 one-shot trigger, 11 retrigger |
| ext_in | input | 1 | Asynchronous external input |
| count_q | output | 8 | Live count |
| irq | output | 1 | End-of-count pulse |
| tout | output | 1 | Toggles on every end of count |

## Verification
Modulo-n runs sweep several prescale and start values, including the encodings 0 = 64 and 0 = 256. The first interval after a load falls in a window set by the phase of the divide-by-four clock. Every later interval must equal prescale × start × 4 exactly, which separates divide errors from reload errors. Separate runs with the external clock, the gate held low then high, and two falling trigger edges 20 cycles apart distinguish the four external-input roles. The trigger runs show whether the second edge restarted the interval or was ignored. A stop/resume run and a single-pass run show whether the count is frozen or idle.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int PRE_W = 6;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    XM_CLOCK   = 2'b00,
    XM_GATE    = 2'b01,
    XM_ONESHOT = 2'b10,
    XM_RETRIG  = 2'b11
  } xmode_t;

  typedef struct packed {
    logic [PRE_W-1:0] div;
    logic             src_int;
    logic             reload;
  } cfg_t;

  // prescale length: field value, zero standing for 2**PRE_W
  function automatic logic [PRE_W:0] presc_span(input logic [PRE_W-1:0] f);
    return (f == '0) ? (PRE_W+1)'(1 << PRE_W) : {1'b0, f};
  endfunction
endpackage

// File: rtl/ptmr_insync.sv
module ptmr_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W:0] pcnt;
  logic [PRE_W:0] span;

  assign span = presc_span(div);
  assign tick = step & ~restart & (pcnt <= (PRE_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= (PRE_W+1)'(1);
    else if (restart) pcnt <= span;
    else if (step)    pcnt <= (pcnt <= (PRE_W+1)'(1)) ? span : pcnt - 1'b1;
  end

  assert_presc_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt >= (PRE_W+1)'(1)) && (pcnt <= (PRE_W+1)'(1 << PRE_W)));
endmodule

// File: rtl/ptmr_down.sv
module ptmr_down
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init,
  output logic [CNT_W-1:0] cnt,
  output logic             eoc
);
  assign eoc = tick & ~load & (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= init;
    else if (eoc && reload) cnt <= init;
    else if (tick)          cnt <= cnt - 1'b1;
  end

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && reload) |=> (cnt == $past(init)));
  assert_single_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !reload) |=> (cnt == '0));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_init,
  input  logic             wr_cfg,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  input  logic             run_en,
  input  logic [1:0]       ext_mode,
  input  logic             ext_in,
  output logic [CNT_W-1:0] count_q,
  output logic             irq,
  output logic             tout
);
  localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

  logic [DW-1:0]    div_q;
  logic [CNT_W-1:0] init_q;
  cfg_t             cfg_q;
  logic             armed;
  logic             int_tick, gate_lvl, x_rise, x_fall;
  logic             src_tick, trig_load, load_evt, count_en, step, ptick, eoc;
  xmode_t           xm;

  assign xm = xmode_t'(ext_mode);

  ptmr_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_in),
    .level(gate_lvl), .rise(x_rise), .fall(x_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           div_q <= '0;
    else if (div_q == DW'(INT_DIV - 1))   div_q <= '0;
    else                                  div_q <= div_q + 1'b1;
  end
  assign int_tick = (div_q == DW'(INT_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_init) init_q <= wr_data;
      if (wr_cfg)  cfg_q  <= cfg_t'(wr_data);
    end
  end

  assign src_tick  = cfg_q.src_int ? (int_tick & ((xm != XM_GATE) | gate_lvl)) : x_rise;
  assign trig_load = cfg_q.src_int & x_fall &
                     ((xm == XM_RETRIG) | ((xm == XM_ONESHOT) & ~armed));
  assign load_evt  = load | trig_load;
  assign count_en  = armed & run_en;
  assign step      = src_tick & count_en;

  ptmr_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load_evt), .step(step),
    .div(cfg_q.div), .tick(ptick));

  ptmr_down u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .tick(ptick),
    .reload(cfg_q.reload), .init(init_q), .cnt(count_q), .eoc(eoc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      irq   <= 1'b0;
      tout  <= 1'b0;
    end else begin
      if (load_evt)                  armed <= 1'b1;
      else if (eoc && !cfg_q.reload) armed <= 1'b0;
      irq  <= eoc;
      tout <= tout ^ eoc;
    end
  end

  assert_irq_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !load_evt) |=> $stable(count_q));
  assert_single_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cfg_q.reload && !load_evt) |=> !armed);
  assert_tout_toggle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tout != $past(tout)));
  assert_oneshot_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load && cfg_q.src_int && xm == XM_ONESHOT) |-> !load_evt);
endmodule

// File: tb/ptmr_top_test.sv
module ptmr_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_init = 1'b0, wr_cfg = 1'b0, load = 1'b0, run_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] ext_mode = 2'b00;
  logic       ext_drv = 1'b1, xclk_on = 1'b0, xclk_sig = 1'b0;
  logic       ext_in;
  logic [7:0] count_q;
  logic       irq, tout;
  int         nvec = 0, nbad = 0, cyc = 0, xph = 0;
  logic       last_tout = 1'b0;

  always #2.5 clk = ~clk;

  assign ext_in = xclk_on ? xclk_sig : ext_drv;

  ptmr_top uut (.clk(clk), .rst_n(rst_n), .wr_init(wr_init), .wr_cfg(wr_cfg),
    .wr_data(wr_data), .load(load), .run_en(run_en), .ext_mode(ext_mode),
    .ext_in(ext_in), .count_q(count_q), .irq(irq), .tout(tout));

  always @(negedge clk) begin
    if (xclk_on) begin
      xph = xph + 1;
      if (xph == 4) begin xph = 0; xclk_sig = ~xclk_sig; end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      nbad = nbad + 1;
      $display("FAIL watchdog: act=%0d exp<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec = nvec + 1;
    if (!ok) begin
      nbad = nbad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit is_cfg, input logic [7:0] d);
    @(negedge clk);
    wr_data = d; wr_cfg = is_cfg; wr_init = ~is_cfg;
    @(negedge clk);
    wr_cfg = 1'b0; wr_init = 1'b0;
  endtask

  task automatic pulse_load;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (n >= 0) begin
      @(negedge clk);
      n = n + 1;
      if (irq) break;
      if (n >= lim) n = -1;
    end
  endtask

  task automatic tout_chk(input string req);
    chk(tout != last_tout, req, int'(tout), int'(~last_tout));
    last_tout = tout;
  endtask

  function automatic int span(input int f, input int w);
    return (f == 0) ? (1 << w) : f;
  endfunction

  // two falling trigger edges 20 cycles apart; t = cycles from first edge to irq
  task automatic trig_run(output int t);
    int n;
    @(negedge clk); ext_drv = 1'b0;
    repeat (4) @(negedge clk); ext_drv = 1'b1;
    repeat (16) @(negedge clk); ext_drv = 1'b0;
    repeat (4) @(negedge clk); ext_drv = 1'b1;
    wait_irq(80, n);
    t = (n < 0) ? -1 : 24 + n;
  endtask

  initial begin
    int n, n2, p, q, per, c;
    int plist[4] = '{1, 2, 3, 0};
    int nlist[5] = '{1, 2, 3, 7, 0};
    repeat (3) @(negedge clk);
    chk(count_q == 0, "R6 reset count", count_q, 0);
    chk(irq == 0, "R3 reset irq", irq, 0);
    chk(tout == 0, "R13 reset tout", tout, 0);
    rst_n = 1'b1;

    // R1 R2 R5 R8 modulo sweep on the internal source
    foreach (plist[i]) foreach (nlist[j]) begin
      if (plist[i] == 0 && nlist[j] == 0) continue;
      run_en = 1'b0;
      wr(1'b1, {plist[i][5:0], 1'b1, 1'b1});
      wr(1'b0, nlist[j][7:0]);
      run_en = 1'b1;
      pulse_load();
      p = span(plist[i], 6); q = span(nlist[j], 8); per = 4 * p * q;
      wait_irq(per + 8, n);
      chk(n >= per - 3 && n <= per, "R8 first interval", n, per);
      tout_chk("R13 toggle");
      wait_irq(per + 8, n2);
      chk(n2 == per, "R1 R2 R5 period", n2, per);
      tout_chk("R13 toggle");
      @(negedge clk);
      chk(irq == 0, "R3 one-cycle pulse", irq, 0);
    end

    // R4 single pass
    run_en = 1'b0;
    wr(1'b1, 8'h06);
    wr(1'b0, 8'd5);
    run_en = 1'b1;
    pulse_load();
    wait_irq(40, n);
    chk(n > 0, "R4 single pass fires", n, 20);
    tout_chk("R13 toggle");
    @(negedge clk);
    chk(count_q == 0, "R4 idle count", count_q, 0);
    wait_irq(200, n);
    chk(n == -1, "R4 no second irq", n, -1);

    // R6 R7 load, stop, resume
    run_en = 1'b0;
    wr(1'b1, 8'h0B);
    wr(1'b0, 8'd50);
    run_en = 1'b1;
    load = 1'b1;
    @(negedge clk); load = 1'b0;
    chk(count_q == 50, "R6 load value", count_q, 50);
    repeat (100) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    c = count_q;
    chk(c < 50 && c > 30, "R7 counted before stop", c, 38);
    repeat (60) @(negedge clk);
    chk(count_q == c, "R7 held while stopped", count_q, c);
    run_en = 1'b1;
    repeat (24) @(negedge clk);
    chk(count_q == c - 3 || count_q == c - 2, "R7 resumed from held value", count_q, c - 3);
    pulse_load();
    chk(count_q == 50, "R6 restart mid-count", count_q, 50);

    // R9 external clock, one rising edge every 8 cycles
    wr(1'b1, 8'h05);
    wr(1'b0, 8'd3);
    xclk_on = 1'b1;
    pulse_load();
    wait_irq(60, n);
    tout_chk("R13 toggle");
    wait_irq(60, n);
    chk(n == 24, "R9 ext period p1 n3", n, 24);
    tout_chk("R13 toggle");
    wr(1'b1, 8'h09);
    wr(1'b0, 8'd2);
    pulse_load();
    wait_irq(80, n);
    tout_chk("R13 toggle");
    wait_irq(80, n);
    chk(n == 32, "R9 ext period p2 n2", n, 32);
    tout_chk("R13 toggle");
    xclk_on = 1'b0; ext_drv = 1'b1;
    repeat (4) @(negedge clk);
    pulse_load();
    wait_irq(80, n);
    chk(n == -1, "R9 idle input no irq", n, -1);
    chk(count_q == 2, "R9 idle input count held", count_q, 2);

    // R10 gate
    ext_drv = 1'b0; ext_mode = 2'b01;
    wr(1'b1, 8'h07);
    wr(1'b0, 8'd4);
    repeat (4) @(negedge clk);
    pulse_load();
    wait_irq(100, n);
    chk(n == -1, "R10 gate low no irq", n, -1);
    chk(count_q == 4, "R10 gate low count held", count_q, 4);
    ext_drv = 1'b1;
    wait_irq(40, n);
    tout_chk("R13 toggle");
    wait_irq(40, n);
    chk(n == 16, "R10 gate high period", n, 16);
    tout_chk("R13 toggle");

    // R11 one-shot trigger: disarm with a short single pass first
    ext_mode = 2'b10;
    wr(1'b1, 8'h06);
    wr(1'b0, 8'd1);
    pulse_load();
    wait_irq(20, n);
    tout_chk("R13 toggle");
    wr(1'b0, 8'd10);
    wait_irq(40, n);
    chk(n == -1, "R11 no start without edge", n, -1);
    trig_run(n);
    chk(n >= 39 && n <= 44, "R11 second edge ignored", n, 42);
    tout_chk("R13 toggle");
    wait_irq(60, n);
    chk(n == -1, "R11 single pass after trigger", n, -1);

    // R12 retrigger
    ext_mode = 2'b11;
    trig_run(n);
    chk(n >= 59 && n <= 64, "R12 second edge reloads", n, 62);
    tout_chk("R13 toggle");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule